// File: doc/BRIEF.md
# Mailbox Flash Transfer Sequencer

This block is the host-side engine that moves a byte range of any length into or out of flash through a register mailbox. The mailbox has sixteen 32-bit data registers, a command register and a status register. A single start pulse carries the direction, a byte address and a byte length. The sequencer cuts the range into chunks of up to 64 bytes. For each chunk it writes the data registers (for writes) and then the command word. It polls the command register until the hardware clears the request bit, reads the status, and for reads unloads the data registers. When the transfer ends, a one-cycle done pulse carries a result code.

Bytes to be written enter on a valid/ready byte stream. Bytes read from flash leave on a valid-only byte stream in address order. Register accesses use a request/acknowledge handshake toward a transport that is outside this block. Timeouts are counted in clock cycles. A chunk that times out is repeated out of a retry budget that is shared by the whole transfer. Writes aimed at the fixed header region are sent to one fixed address with a header flag set, and their size is limited.

Top module: `mbox_xfer_seq`

## Requirements
- R1: Each chunk carries n = min(remaining, 64 - off) bytes, where off is the low two address bits (0 for header writes). The chunk covers ceil((off+n)/4) dwords starting at the address aligned down to 4. The next chunk starts at address + n, and the transfer stops when the length is used up.
- R2: Register indices are: data dword k at index k (0..15), command at 16, status at 17. The command word is: bits 31:28 opcode (0 write, 2 read), bits 27:24 dword count, bits 23:2 dword address, bit 1 header flag, bit 0 request (always 1 when written).
- R3: A read command's count field holds the dword count when it is below 16 and 0 for 16 dwords. A write command's count field holds the dword count minus one.
- R4: For a write chunk, stream bytes are taken first. The data registers are then written in ascending index order, and the command word is written last. Buffer bytes outside [off, off+n) are sent as 0xFF. Byte j of a dword sits in bits 8j+7:8j.
- R5: After a command is written, the command register is read repeatedly until bit 0 reads 0, with POLL_GAP idle cycles between reads. If bit 0 is still 1 after POLL_TIMEOUT cycles, the chunk has timed out.
- R6: The status register is read after completion. Status bits 3:0 map to results as follows: 0 means the chunk succeeded, 1 gives result 1 (authentication), 2 gives result 2 (access), and any other value gives result 3 (I/O).
- R7: A timed-out chunk is repeated in full, and a write chunk reloads its data registers. Repeats come from a budget of RETRIES (3) per transfer, and once the budget is spent the transfer ends with result 3. A nonzero status ends the transfer at once, with no repeat.
- R8: After a read chunk succeeds, the data registers are read in ascending order. The bytes in [off, off+n) are presented on rd_valid/rd_data in address order.
- R9: A write with address >= CSS_ADDR sets the header flag in every command. Every command uses address field CSS_ADDR[23:2], and off is taken as 0.
- R10: A header write longer than CSS_MAX bytes ends with result 4. It makes no register access and takes no stream bytes.
- R11: A zero-length transfer ends with result 0 and makes no register access.
- R12: done is high for exactly one cycle per transfer, and result is valid during that cycle. Result codes are 0 ok, 1 auth, 2 access, 3 I/O, 4 size.
- R13: Once reg_req is raised, reg_req, reg_wr, reg_idx and reg_wdata stay constant until the cycle in which reg_ack is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, sampled while idle |
| start_wr | input | 1 | 1 for a write transfer, 0 for a read transfer |
| start_addr | input | 32 | Byte address of the transfer |
| start_len | input | LEN_W | Byte length of the transfer |
| done | output | 1 | One-cycle completion pulse |
| result | output | 3 | Result code, valid while done is high |
| reg_req | output | 1 | Register access request |
| reg_wr | output | 1 | 1 for a register write, 0 for a register read |
| reg_idx | output | 5 | Register index |
| reg_wdata | output | 32 | Register write data |
| reg_ack | input | 1 | Access complete; reg_rdata is valid for reads |
| reg_rdata | input | 32 | Register read data |
| wd_valid | input | 1 | Write byte available |
| wd_data | input | 8 | Write byte |
| wd_ready | output | 1 | Write byte accepted this cycle when wd_valid is high |
| rd_valid | output | 1 | Read byte valid |
| rd_data | output | 8 | Read byte |

## Verification
The assertions assume a transport that raises reg_ack only while reg_req is high, never in two consecutive cycles, and that otherwise leaves the request pending for as long as it likes. They also assume that start is raised only while the block is idle. The bench's mailbox model acknowledges one cycle after it sees a request. The bench pulses start only after the previous done and keeps it high for a single cycle. The model keeps the request bit set for a programmable number of commands, which forces timeouts without breaking the handshake.

// File: rtl/mbox_xfer_seq.sv
module mbox_xfer_seq #(
  parameter int          LEN_W        = 16,
  parameter int          POLL_TIMEOUT = 4096,
  parameter int          POLL_GAP     = 4,
  parameter int          RETRIES      = 3,
  parameter logic [31:0] CSS_ADDR     = 32'h00FF_0000,
  parameter int          CSS_MAX      = 128
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_wr,
  input  logic [31:0]      start_addr,
  input  logic [LEN_W-1:0] start_len,
  output logic             done,
  output logic [2:0]       result,
  output logic             reg_req,
  output logic             reg_wr,
  output logic [4:0]       reg_idx,
  output logic [31:0]      reg_wdata,
  input  logic             reg_ack,
  input  logic [31:0]      reg_rdata,
  input  logic             wd_valid,
  input  logic [7:0]       wd_data,
  output logic             wd_ready,
  output logic             rd_valid,
  output logic [7:0]       rd_data
);
  localparam int TMO_W = $clog2(POLL_TIMEOUT + 2);
  localparam int GAP_W = (POLL_GAP > 1) ? $clog2(POLL_GAP + 1) : 1;
  localparam int RTY_W = $clog2(RETRIES + 2);
  localparam logic [4:0] IDX_CMD  = 5'd16;
  localparam logic [4:0] IDX_STAT = 5'd17;
  localparam logic [2:0] RES_OK = 3'd0, RES_AUTH = 3'd1, RES_ACC = 3'd2, RES_IO = 3'd3, RES_SIZE = 3'd4;

  typedef enum logic [3:0] {S_IDLE, S_FILL, S_LOAD, S_CMD, S_POLL, S_GAP, S_STAT, S_UNLD, S_EMIT} st_t;

  st_t              state;
  logic [31:0]      cur_addr;
  logic [LEN_W-1:0] rem;
  logic             wr, css;
  logic [6:0]       bi;
  logic [4:0]       di;
  logic [1:0]       eb;
  logic [31:0]      word;
  logic [TMO_W-1:0] tmo;
  logic [GAP_W-1:0] gc;
  logic [RTY_W-1:0] retr;
  logic [7:0]       bbuf [64];

  logic [1:0]       off;
  logic [6:0]       room, endb, cnb7, epos;
  logic [LEN_W-1:0] cnb;
  logic [4:0]       cdw;
  logic [3:0]       cnt_f;
  logic [21:0]      dwa;
  logic [31:0]      cmdw, ldw;
  logic             in_fill, in_emit, last_fill, last_dw;

  assign off   = css ? 2'd0 : cur_addr[1:0];
  assign room  = 7'd64 - {5'd0, off};
  assign cnb   = (rem > LEN_W'(room)) ? LEN_W'(room) : rem;
  assign cnb7  = cnb[6:0];
  assign endb  = {5'd0, off} + cnb7;
  assign cdw   = 5'((endb + 7'd3) >> 2);
  assign cnt_f = wr ? 4'(cdw - 5'd1) : ((cdw == 5'd16) ? 4'd0 : cdw[3:0]);
  assign dwa   = css ? CSS_ADDR[23:2] : cur_addr[23:2];
  assign cmdw  = {(wr ? 4'h0 : 4'h2), cnt_f, dwa, css, 1'b1};
  assign ldw   = {bbuf[{di[3:0], 2'd3}], bbuf[{di[3:0], 2'd2}], bbuf[{di[3:0], 2'd1}], bbuf[{di[3:0], 2'd0}]};
  assign epos  = {di, eb};

  assign in_fill   = (bi >= {5'd0, off}) && (bi < endb);
  assign in_emit   = (epos >= {5'd0, off}) && (epos < endb);
  assign last_fill = (bi == ({cdw, 2'b00} - 7'd1));
  assign last_dw   = (di == cdw - 5'd1);

  assign reg_req   = (state == S_LOAD) || (state == S_CMD) || (state == S_POLL) ||
                     (state == S_STAT) || (state == S_UNLD);
  assign reg_wr    = (state == S_LOAD) || (state == S_CMD);
  assign reg_idx   = ((state == S_LOAD) || (state == S_UNLD)) ? di :
                     ((state == S_CMD)  || (state == S_POLL)) ? IDX_CMD :
                     (state == S_STAT) ? IDX_STAT : 5'd0;
  assign reg_wdata = (state == S_LOAD) ? ldw : (state == S_CMD) ? cmdw : 32'd0;
  assign wd_ready  = (state == S_FILL) && in_fill;
  assign rd_valid  = (state == S_EMIT) && in_emit;
  assign rd_data   = word[{eb, 3'b000} +: 8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cur_addr <= '0;
      rem      <= '0;
      wr       <= 1'b0;
      css      <= 1'b0;
      bi       <= '0;
      di       <= '0;
      eb       <= '0;
      word     <= '0;
      tmo      <= '0;
      gc       <= '0;
      retr     <= '0;
      done     <= 1'b0;
      result   <= RES_OK;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          cur_addr <= start_addr;
          rem      <= start_len;
          wr       <= start_wr;
          css      <= start_wr && (start_addr >= CSS_ADDR);
          retr     <= RTY_W'(RETRIES);
          bi       <= '0;
          di       <= '0;
          if (start_len == '0) begin
            done <= 1'b1; result <= RES_OK;
          end else if (start_wr && (start_addr >= CSS_ADDR) && (start_len > LEN_W'(CSS_MAX))) begin
            done <= 1'b1; result <= RES_SIZE;
          end else begin
            state <= start_wr ? S_FILL : S_CMD;
          end
        end
        S_FILL: if (!in_fill || wd_valid) begin
          bbuf[bi[5:0]] <= in_fill ? wd_data : 8'hFF;
          bi <= bi + 7'd1;
          if (last_fill) begin
            state <= S_LOAD;
            di    <= '0;
          end
        end
        S_LOAD: if (reg_ack) begin
          di <= di + 5'd1;
          if (last_dw) state <= S_CMD;
        end
        S_CMD: if (reg_ack) begin
          tmo   <= '0;
          state <= S_POLL;
        end
        S_POLL: begin
          if (tmo != '1) tmo <= tmo + 1'b1;
          if (reg_ack) begin
            if (!reg_rdata[0]) begin
              state <= S_STAT;
            end else if (tmo >= TMO_W'(POLL_TIMEOUT)) begin
              if (retr != '0) begin
                retr  <= retr - 1'b1;
                di    <= '0;
                state <= wr ? S_LOAD : S_CMD;
              end else begin
                done  <= 1'b1;
                result <= RES_IO;
                state <= S_IDLE;
              end
            end else begin
              gc    <= '0;
              state <= S_GAP;
            end
          end
        end
        S_GAP: begin
          if (tmo != '1) tmo <= tmo + 1'b1;
          gc <= gc + 1'b1;
          if (gc >= GAP_W'(POLL_GAP - 1)) state <= S_POLL;
        end
        S_STAT: if (reg_ack) begin
          if (reg_rdata[3:0] != 4'd0) begin
            done   <= 1'b1;
            result <= (reg_rdata[3:0] == 4'd1) ? RES_AUTH :
                      (reg_rdata[3:0] == 4'd2) ? RES_ACC : RES_IO;
            state  <= S_IDLE;
          end else if (!wr) begin
            di    <= '0;
            state <= S_UNLD;
          end else begin
            cur_addr <= cur_addr + 32'(cnb);
            rem      <= rem - cnb;
            bi       <= '0;
            if (rem == cnb) begin
              done <= 1'b1; result <= RES_OK; state <= S_IDLE;
            end else begin
              state <= S_FILL;
            end
          end
        end
        S_UNLD: if (reg_ack) begin
          word  <= reg_rdata;
          eb    <= '0;
          state <= S_EMIT;
        end
        S_EMIT: begin
          eb <= eb + 2'd1;
          if (eb == 2'd3) begin
            if (last_dw) begin
              cur_addr <= cur_addr + 32'(cnb);
              rem      <= rem - cnb;
              if (rem == cnb) begin
                done <= 1'b1; result <= RES_OK; state <= S_IDLE;
              end else begin
                state <= S_CMD;
              end
            end else begin
              di    <= di + 5'd1;
              state <= S_UNLD;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mbox_xfer_seq_chk.sv
module mbox_xfer_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        done,
  input logic [2:0]  result,
  input logic        reg_req,
  input logic        reg_wr,
  input logic [4:0]  reg_idx,
  input logic [31:0] reg_wdata,
  input logic        reg_ack,
  input logic        wd_ready,
  input logic        rd_valid
);
  assert_req_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && !reg_ack) |=> (reg_req && $stable(reg_wr) && $stable(reg_idx) && $stable(reg_wdata)));

  assert_result_range_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result <= 3'd4));

  assert_cmd_request_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && reg_wr && reg_idx == 5'd16) |-> reg_wdata[0]);

  assert_hdr_only_on_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && reg_wr && reg_idx == 5'd16 && reg_wdata[31:28] == 4'h2) |-> !reg_wdata[1]);

  assert_fill_apart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wd_ready |-> !reg_req);

  assert_emit_apart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (!reg_req && !wd_ready));
endmodule

bind mbox_xfer_seq mbox_xfer_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .result(result),
  .reg_req(reg_req), .reg_wr(reg_wr), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
  .reg_ack(reg_ack), .wd_ready(wd_ready), .rd_valid(rd_valid)
);

// File: tb/mbox_xfer_seq_bench.sv
module mbox_xfer_seq_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, start, start_wr, done, reg_req, reg_wr, reg_ack, wd_valid, wd_ready, rd_valid;
  logic [31:0] start_addr, reg_wdata, reg_rdata;
  logic [15:0] start_len;
  logic [2:0]  result;
  logic [4:0]  reg_idx;
  logic [7:0]  wd_data, rd_data;

  localparam logic [31:0] HDR = 32'h00FF_0000;

  mbox_xfer_seq #(.POLL_TIMEOUT(40), .POLL_GAP(4)) u_mbox_xfer_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_wr(start_wr), .start_addr(start_addr),
    .start_len(start_len), .done(done), .result(result), .reg_req(reg_req), .reg_wr(reg_wr),
    .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_ack(reg_ack), .reg_rdata(reg_rdata),
    .wd_valid(wd_valid), .wd_data(wd_data), .wd_ready(wd_ready), .rd_valid(rd_valid), .rd_data(rd_data));

  int tests = 0, fails = 0;
  logic [7:0]  mem [256];
  logic [7:0]  hmem [64];
  logic [31:0] dreg [16];
  logic [31:0] cmd_log [16];
  logic [31:0] last_cmd;
  int ncmd, nacc, ndw, npoll, hang_left, busy_left, stat_code, viol;
  logic [7:0] wsrc [128];
  logic [7:0] rbuf [128];
  int widx, rcnt;
  logic [2:0] res;

  assign wd_data = wsrc[widx[6:0]];

  function automatic void exec(input logic [31:0] w);
    int dw;
    dw = (w[31:28] == 4'h2) ? ((w[27:24] == 0) ? 16 : int'(w[27:24])) : int'(w[27:24]) + 1;
    for (int k = 0; k < dw; k++)
      for (int b = 0; b < 4; b++) begin
        int a;
        a = (int'(w[23:2]) * 4 + k * 4 + b) & 255;
        if (w[31:28] == 4'h2) dreg[k][b*8 +: 8] = mem[a];
        else if (w[1]) hmem[(k*4 + b) & 63] = dreg[k][b*8 +: 8];
        else mem[a] = dreg[k][b*8 +: 8];
      end
  endfunction

  always @(posedge clk) begin
    reg_ack <= 1'b0;
    if (rst_n && reg_req && !reg_ack) begin
      reg_ack <= 1'b1;
      nacc++;
      reg_rdata <= 32'd0;
      if (reg_wr) begin
        if (reg_idx < 5'd16) begin dreg[reg_idx[3:0]] = reg_wdata; ndw++; end
        else if (reg_idx == 5'd16) begin
          cmd_log[ncmd & 15] = reg_wdata; ncmd++; last_cmd = reg_wdata;
          if (hang_left > 0) begin hang_left--; busy_left = 1000000; end
          else begin busy_left = 2; exec(reg_wdata); end
        end
      end else begin
        if (reg_idx < 5'd16) reg_rdata <= dreg[reg_idx[3:0]];
        else if (reg_idx == 5'd16) begin
          npoll++;
          reg_rdata <= {last_cmd[31:1], busy_left > 0};
          if (busy_left > 0) busy_left--;
        end else reg_rdata <= 32'(stat_code);
      end
    end
  end

  logic p_req, p_ack, p_wr;
  logic [4:0] p_idx;
  logic [31:0] p_wd;
  always @(posedge clk) begin
    if (rst_n && p_req && !p_ack && (!reg_req || reg_wr != p_wr || reg_idx != p_idx || reg_wdata != p_wd)) viol++;
    p_req <= reg_req; p_ack <= reg_ack; p_wr <= reg_wr; p_idx <= reg_idx; p_wd <= reg_wdata;
  end

  always @(posedge clk) begin
    if (wd_valid && wd_ready) widx <= widx + 1;
    if (rd_valid) begin rbuf[rcnt[6:0]] <= rd_data; rcnt <= rcnt + 1; end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic run(input logic wr, input logic [31:0] a, input int n);
    @(negedge clk);
    widx = 0; rcnt = 0; ncmd = 0; nacc = 0; ndw = 0; npoll = 0;
    start = 1'b1; start_wr = wr; start_addr = a; start_len = 16'(n);
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    res = result;
    @(negedge clk);
    chk(done == 1'b0, "R12 done one cycle", done, 0);
  endtask

  task automatic t_reset();
    chk(!done && !reg_req && !wd_ready && !rd_valid, "R12 reset outputs idle",
        {done, reg_req, wd_ready, rd_valid}, 0);
  endtask

  task automatic t_aligned();
    for (int k = 0; k < 128; k++) wsrc[k] = 8'(8'hA0 + k);
    run(1'b1, 32'h20, 8);
    chk(res == 0, "R6 write ok", res, 0);
    chk(ncmd == 1 && cmd_log[0] == 32'h0100_0021, "R2 R3 write command word", cmd_log[0], 32'h0100_0021);
    chk(ndw == 2, "R4 data writes", ndw, 2);
    chk(npoll == 3, "R5 polls until clear", npoll, 3);
    for (int k = 0; k < 8; k++) chk(mem[32 + k] == wsrc[k], "R4 written byte", mem[32 + k], wsrc[k]);
    run(1'b0, 32'h20, 8);
    chk(cmd_log[0] == 32'h2200_0021, "R3 read command word", cmd_log[0], 32'h2200_0021);
    chk(rcnt == 8, "R8 read byte count", rcnt, 8);
    for (int k = 0; k < 8; k++) chk(rbuf[k] == wsrc[k], "R8 read byte", rbuf[k], wsrc[k]);
  endtask

  task automatic t_full_read();
    run(1'b0, 32'h40, 64);
    chk(res == 0 && ncmd == 1, "R1 single chunk", ncmd, 1);
    chk(cmd_log[0] == 32'h2000_0041, "R3 full read count zero", cmd_log[0], 32'h2000_0041);
    chk(rcnt == 64, "R8 full byte count", rcnt, 64);
    for (int k = 0; k < 64; k++) chk(rbuf[k] == mem[64 + k], "R8 full read byte", rbuf[k], mem[64 + k]);
  endtask

  task automatic t_unaligned();
    for (int k = 0; k < 128; k++) wsrc[k] = 8'(k * 7 + 1);
    mem[8'h10] = 8'h00; mem[8'h77] = 8'h00;
    run(1'b1, 32'h13, 100);
    chk(res == 0 && ncmd == 2, "R1 two chunks", ncmd, 2);
    chk(cmd_log[0] == 32'h0F00_0011, "R1 R3 first write chunk", cmd_log[0], 32'h0F00_0011);
    chk(cmd_log[1] == 32'h0900_0051, "R1 R3 second write chunk", cmd_log[1], 32'h0900_0051);
    chk(mem[8'h10] == 8'hFF, "R4 leading pad", mem[8'h10], 8'hFF);
    chk(mem[8'h77] == 8'hFF, "R4 trailing pad", mem[8'h77], 8'hFF);
    for (int k = 0; k < 100; k++) chk(mem[8'h13 + k] == wsrc[k], "R1 unaligned write byte", mem[8'h13 + k], wsrc[k]);
    run(1'b0, 32'h13, 100);
    chk(cmd_log[0] == 32'h2000_0011 && cmd_log[1] == 32'h2A00_0051, "R1 read chunks", cmd_log[1], 32'h2A00_0051);
    chk(rcnt == 100, "R8 unaligned count", rcnt, 100);
    for (int k = 0; k < 100; k++) chk(rbuf[k] == wsrc[k], "R8 unaligned read byte", rbuf[k], wsrc[k]);
  endtask

  task automatic t_status();
    stat_code = 1; run(1'b0, 32'h0, 4);
    chk(res == 1, "R6 status 1", res, 1);
    chk(ncmd == 1, "R7 no repeat on error", ncmd, 1);
    stat_code = 2; run(1'b1, 32'h0, 4);
    chk(res == 2, "R6 status 2", res, 2);
    stat_code = 9; run(1'b0, 32'h0, 4);
    chk(res == 3, "R6 other status", res, 3);
    chk(rcnt == 0, "R8 nothing streamed on error", rcnt, 0);
    stat_code = 0;
  endtask

  task automatic t_timeout();
    hang_left = 2; run(1'b0, 32'h20, 8);
    chk(res == 0 && ncmd == 3, "R7 two repeats then ok", ncmd, 3);
    chk(rbuf[0] == mem[32] && rcnt == 8, "R7 data after repeat", rbuf[0], mem[32]);
    hang_left = 4; run(1'b1, 32'h80, 4);
    chk(res == 3, "R7 budget spent", res, 3);
    chk(ncmd == 4, "R7 four attempts", ncmd, 4);
    chk(ndw == 4, "R7 data reloaded each attempt", ndw, 4);
    hang_left = 0;
  endtask

  task automatic t_header();
    for (int k = 0; k < 128; k++) wsrc[k] = 8'(8'h30 + k);
    run(1'b1, HDR + 5, 16);
    chk(res == 0 && ncmd == 1, "R9 header write ok", ncmd, 1);
    chk(cmd_log[0] == 32'h03FF_0003, "R9 header command", cmd_log[0], 32'h03FF_0003);
    for (int k = 0; k < 16; k++) chk(hmem[k] == wsrc[k], "R9 header byte at zero offset", hmem[k], wsrc[k]);
    run(1'b1, HDR, 129);
    chk(res == 4, "R10 oversize header", res, 4);
    chk(nacc == 0 && widx == 0, "R10 no access", nacc + widx, 0);
  endtask

  task automatic t_zero();
    run(1'b0, 32'h10, 0);
    chk(res == 0, "R11 zero length ok", res, 0);
    chk(nacc == 0 && rcnt == 0, "R11 no access", nacc, 0);
    chk(viol == 0, "R13 request held until ack", viol, 0);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    fails++; tests++;
    $display("FAIL watchdog actual=%0d expected<150000", cyc);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < 256; k++) mem[k] = 8'(k ^ 8'h5A);
    for (int k = 0; k < 64; k++) hmem[k] = 8'h00;
    for (int k = 0; k < 16; k++) dreg[k] = 32'd0;
    ncmd = 0; nacc = 0; ndw = 0; npoll = 0; hang_left = 0; busy_left = 0; stat_code = 0; viol = 0;
    widx = 0; rcnt = 0; last_cmd = 32'd0; reg_rdata = 32'd0;
    rst_n = 1'b0; start = 1'b0; start_wr = 1'b0; start_addr = 32'd0; start_len = 16'd0; wd_valid = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_aligned();
    t_full_read();
    t_unaligned();
    t_status();
    t_timeout();
    t_header();
    t_zero();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule